// File: doc/BRIEF.md
# SIMD Byte Permute Unit

This unit rearranges the bytes of one or two vector operands in a single pass. It serves the permute slot of a SIMD datapath. Each vector is either 64 or 128 bits wide, and byte k of a vector sits at bits [8k+7:8k].

One opcode selects the permute:
- a sliding byte window over two concatenated operands;
- element reversal inside fixed containers;
- a byte lookup into a table of up to four 64-bit registers, with zeroing or preservation of the old destination on a miss;
- interleave and de-interleave of two vectors;
- a pairwise 2x2 transpose.

Results are registered, so they appear one cycle after the request, qualified by a valid strobe. A request whose parameters do not fit the chosen width or operation raises an error flag. In that case the first operand passes through untouched.

In 64-bit mode only bytes 0..7 of each operand take part, and the upper half of every result is zero. Three permutes write two result vectors: interleave, de-interleave and transpose. All other permutes write one result vector and leave the second result at zero.

Top module: `vperm_unit`

## Requirements
- R1: `out_valid` rises exactly one cycle after a cycle with `in_valid` high, and then carries that request's results. In a cycle without `in_valid`, the next cycle has `out_valid` low and `res_a`, `res_b` and `err` unchanged.
- R2: While reset is asserted, `out_valid`, `err`, `res_a` and `res_b` are all zero.
- R3: Opcode 0 (slide) with lane count N (8 or 16) and shift s < N gives result byte i = byte i+s of the 2N-byte sequence {src_a bytes 0..N-1, then src_b bytes 0..N-1}. In effect, the bottom s bytes of src_b fill the top of the result.
- R4: Opcodes 1, 2 and 3 reverse the order of elements inside containers of 2, 4 and 8 bytes. `esize` gives the element size: 0=8, 1=16, 2=32, 3=64 bits. The source is src_a.
- R5: Opcode 4 (lookup, miss gives zero): each control byte src_b[i] indexes the table, where table byte k is `tbl[8k+7:8k]`. An index at or beyond the table size yields 0.
- R6: Opcode 5 (lookup, miss keeps) works like R5, but on a miss result byte i takes `dst_old` byte i.
- R7: The table holds `tbl_len`+1 registers of 8 bytes each, so 8 to 32 bytes. Bytes past that count are misses even if they are present on `tbl`.
- R8: Opcode 6 (interleave) with M elements per vector builds the sequence a0,b0,a1,b1,... Its first M elements go to `res_a` and its next M elements go to `res_b`.
- R9: Opcode 7 (de-interleave) treats src_a followed by src_b as one sequence. `res_a` takes the even-numbered elements of that sequence and `res_b` takes the odd-numbered ones.
- R10: Opcode 8 (transpose) handles each even element index j. It produces res_a[j]=a[j], res_a[j+1]=b[j], res_b[j]=a[j+1] and res_b[j+1]=b[j+1].
- R11: With `wide`=0, bytes 8..15 of both results are zero for every legal request.
- R12: The following requests are illegal: a slide shift ≥ N; reversal with an element not smaller than its container; interleave, de-interleave or transpose with 64-bit elements; and opcodes 9..15. An illegal request sets `err`, returns `res_a`=src_a (all 128 bits) and `res_b`=0. A legal request clears `err`.
- R13: Slide, reversal and lookup leave `res_b` at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Permute opcode (see R3 to R12) |
| wide | input | 1 | 1 = 128-bit vectors, 0 = 64-bit |
| esize | input | 2 | Element size code: 0=8, 1=16, 2=32, 3=64 bits |
| imm | input | 4 | Slide byte shift |
| tbl_len | input | 2 | Number of table registers minus one |
| src_a | input | 128 | First operand |
| src_b | input | 128 | Second operand, or the lookup control vector |
| tbl | input | 256 | Table registers, register k at bits [64k+63:64k] |
| dst_old | input | 128 | Previous destination value for keep-on-miss lookup |
| out_valid | output | 1 | Result strobe |
| res_a | output | 128 | First result vector |
| res_b | output | 128 | Second result vector |
| err | output | 1 | Illegal request flag |

## Verification
Every permute is a pure function of one request, so a wrong byte route or a bad legality decision shows up in the very next result, one cycle after the request. The lookup paths need misses at the table boundary and far beyond it, in both miss modes. The dual-result permutes need element sizes of 8, 16 and 32 bits in both widths, because a slip in element-index arithmetic only shows for some sizes. A result register that fails to hold between requests shows as changed outputs on an idle cycle.

// File: rtl/vperm_pkg.sv
package vperm_pkg;
  typedef enum logic [3:0] {
    POP_SLIDE    = 4'd0,
    POP_REV16    = 4'd1,
    POP_REV32    = 4'd2,
    POP_REV64    = 4'd3,
    POP_LUT_ZERO = 4'd4,
    POP_LUT_KEEP = 4'd5,
    POP_ZIP      = 4'd6,
    POP_UNZIP    = 4'd7,
    POP_TRN      = 4'd8
  } perm_op_e;

  localparam logic [1:0] PAIR_ZIP   = 2'd0;
  localparam logic [1:0] PAIR_UNZIP = 2'd1;
  localparam logic [1:0] PAIR_TRN   = 2'd2;
endpackage

// File: rtl/vperm_slide.sv
module vperm_slide #(
  parameter int NB = 16
) (
  input  logic [NB*8-1:0]         a,
  input  logic [NB*8-1:0]         b,
  input  logic                    wide,
  input  logic [$clog2(NB)-1:0]   shift,
  output logic [NB*8-1:0]         y
);
  int lanes;
  int pos;

  always_comb begin
    y     = '0;
    lanes = wide ? NB : NB / 2;
    pos   = 0;
    for (int i = 0; i < NB; i++) begin
      pos = i + int'(shift);
      if (i < lanes) begin
        if (pos < lanes)
          y[8*i +: 8] = a[8*pos +: 8];
        else if (pos - lanes < lanes)
          y[8*i +: 8] = b[8*(pos-lanes) +: 8];
      end
    end
  end
endmodule

// File: rtl/vperm_reverse.sv
module vperm_reverse #(
  parameter int NB = 16
) (
  input  logic [NB*8-1:0] a,
  input  logic            wide,
  input  logic [1:0]      clog,
  input  logic [1:0]      elog,
  output logic [NB*8-1:0] y
);
  int lanes;
  int flip;

  // Reversing element order in a container flips the element-index bits.
  always_comb begin
    y     = '0;
    lanes = wide ? NB : NB / 2;
    flip  = ((1 << clog) - 1) & ~((1 << elog) - 1);
    for (int i = 0; i < NB; i++) begin
      if (i < lanes && (i ^ flip) < NB)
        y[8*i +: 8] = a[8*(i ^ flip) +: 8];
    end
  end
endmodule

// File: rtl/vperm_lookup.sv
module vperm_lookup #(
  parameter int NB    = 16,
  parameter int TREGS = 4,
  parameter int LW    = (TREGS > 1) ? $clog2(TREGS) : 1
) (
  input  logic [NB*8-1:0]    ctrl,
  input  logic [NB*8-1:0]    old,
  input  logic [TREGS*64-1:0] tbl,
  input  logic [LW-1:0]      regs_m1,
  input  logic               keep,
  input  logic               wide,
  output logic [NB*8-1:0]    y
);
  localparam int TBYTES = TREGS * 8;

  int lanes;
  int limit;
  int idx;

  always_comb begin
    y     = '0;
    lanes = wide ? NB : NB / 2;
    limit = (int'(regs_m1) + 1) * 8;
    if (limit > TBYTES) limit = TBYTES;
    idx   = 0;
    for (int i = 0; i < NB; i++) begin
      idx = int'(ctrl[8*i +: 8]);
      if (i < lanes) begin
        if (idx < limit)
          y[8*i +: 8] = tbl[8*idx +: 8];
        else if (keep)
          y[8*i +: 8] = old[8*i +: 8];
      end
    end
  end
endmodule

// File: rtl/vperm_pair.sv
module vperm_pair
  import vperm_pkg::*;
#(
  parameter int NB = 16
) (
  input  logic [NB*8-1:0] a,
  input  logic [NB*8-1:0] b,
  input  logic            wide,
  input  logic [1:0]      elog,
  input  logic [1:0]      mode,
  output logic [NB*8-1:0] ya,
  output logic [NB*8-1:0] yb
);
  int lanes, m, half, lp, q, o, j, t, e, sb;
  logic sel_b;

  // Walk the 2*lanes output bytes; find source vector and element for each.
  always_comb begin
    ya    = '0;
    yb    = '0;
    lanes = wide ? NB : NB / 2;
    m     = lanes >> elog;
    half  = 0; lp = 0; q = 0; o = 0; j = 0; t = 0; e = 0; sb = 0;
    sel_b = 1'b0;
    for (int p = 0; p < 2*NB; p++) begin
      if (p < 2*lanes) begin
        half = (p >= lanes) ? 1 : 0;
        lp   = p - half * lanes;
        q    = p >> elog;
        o    = p & ((1 << elog) - 1);
        j    = q - half * m;
        case (mode)
          PAIR_UNZIP: begin
            t     = (q < m) ? 2*q : 2*(q - m) + 1;
            sel_b = (t >= m);
            e     = sel_b ? t - m : t;
          end
          PAIR_TRN: begin
            sel_b = j[0];
            e     = (half == 0) ? (j[0] ? j - 1 : j) : (j[0] ? j : j + 1);
          end
          default: begin
            sel_b = q[0];
            e     = q >> 1;
          end
        endcase
        sb = (e << elog) + o;
        if (sb < NB) begin
          if (half == 0)
            ya[8*lp +: 8] = sel_b ? b[8*sb +: 8] : a[8*sb +: 8];
          else
            yb[8*lp +: 8] = sel_b ? b[8*sb +: 8] : a[8*sb +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/vperm_unit.sv
module vperm_unit
  import vperm_pkg::*;
#(
  parameter int VBYTES = 16,
  parameter int TREGS  = 4,
  parameter int SHW    = $clog2(VBYTES),
  parameter int LW     = (TREGS > 1) ? $clog2(TREGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [3:0]            op,
  input  logic                  wide,
  input  logic [1:0]            esize,
  input  logic [SHW-1:0]        imm,
  input  logic [LW-1:0]         tbl_len,
  input  logic [VBYTES*8-1:0]   src_a,
  input  logic [VBYTES*8-1:0]   src_b,
  input  logic [TREGS*64-1:0]   tbl,
  input  logic [VBYTES*8-1:0]   dst_old,
  output logic                  out_valid,
  output logic [VBYTES*8-1:0]   res_a,
  output logic [VBYTES*8-1:0]   res_b,
  output logic                  err
);
  localparam int VW = VBYTES * 8;

  logic [VW-1:0] slide_y, rev_y, lut_y, pair_a, pair_b;
  logic [VW-1:0] nxt_a, nxt_b;
  logic [1:0]    pair_mode;
  logic          legal, single;
  logic          vld_q, err_q;
  logic [VW-1:0] a_q, b_q;

  vperm_slide #(.NB(VBYTES)) u_slide (
    .a(src_a), .b(src_b), .wide(wide), .shift(imm), .y(slide_y));

  vperm_reverse #(.NB(VBYTES)) u_rev (
    .a(src_a), .wide(wide), .clog(op[1:0]), .elog(esize), .y(rev_y));

  vperm_lookup #(.NB(VBYTES), .TREGS(TREGS), .LW(LW)) u_lut (
    .ctrl(src_b), .old(dst_old), .tbl(tbl), .regs_m1(tbl_len),
    .keep(op == POP_LUT_KEEP), .wide(wide), .y(lut_y));

  vperm_pair #(.NB(VBYTES)) u_pair (
    .a(src_a), .b(src_b), .wide(wide), .elog(esize), .mode(pair_mode),
    .ya(pair_a), .yb(pair_b));

  always_comb begin
    pair_mode = (op == POP_UNZIP) ? PAIR_UNZIP :
                (op == POP_TRN)   ? PAIR_TRN   : PAIR_ZIP;
  end

  // Decode legality and select the next result.
  always_comb begin
    legal  = 1'b0;
    single = 1'b1;
    nxt_a  = src_a;
    nxt_b  = '0;
    case (op)
      POP_SLIDE: begin
        legal = int'(imm) < (wide ? VBYTES : VBYTES / 2);
        nxt_a = slide_y;
      end
      POP_REV16, POP_REV32, POP_REV64: begin
        legal = esize < op[1:0];
        nxt_a = rev_y;
      end
      POP_LUT_ZERO, POP_LUT_KEEP: begin
        legal = 1'b1;
        nxt_a = lut_y;
      end
      POP_ZIP, POP_UNZIP, POP_TRN: begin
        legal  = (esize != 2'd3);
        single = 1'b0;
        nxt_a  = pair_a;
        nxt_b  = pair_b;
      end
      default: legal = 1'b0;
    endcase
    if (!legal) begin
      nxt_a = src_a;
      nxt_b = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
      a_q   <= '0;
      b_q   <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        err_q <= !legal;
        a_q   <= nxt_a;
        b_q   <= nxt_b;
      end
    end
  end

  assign out_valid = vld_q;
  assign err       = err_q;
  assign res_a     = a_q;
  assign res_b     = b_q;

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(res_a) && $stable(res_b) && $stable(err));

  assert_illegal_passthru_R12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !legal |=> err && res_a == $past(src_a) && res_b == '0);

  assert_narrow_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && legal && !wide |=> res_a[VW-1:VW/2] == '0 && res_b[VW-1:VW/2] == '0);

  assert_single_clears_b_R13: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && legal && single |=> res_b == '0 && !err);
endmodule

// File: tb/test_vperm_unit.sv
`timescale 1ns/1ps
module test_vperm_unit;
  typedef struct {
    logic [127:0] a;
    logic [127:0] b;
    logic         e;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [3:0]   op;
  logic         wide;
  logic [1:0]   esize;
  logic [3:0]   imm;
  logic [1:0]   tbl_len;
  logic [127:0] src_a, src_b, dst_old;
  logic [255:0] tbl;
  logic         out_valid, err;
  logic [127:0] res_a, res_b;

  exp_t         sb_q[$];
  exp_t         last;
  logic         have_last = 1'b0;
  int           n_checks = 0;
  int           n_fails  = 0;

  always #2 clk = ~clk;

  vperm_unit i_vperm_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .wide(wide),
    .esize(esize), .imm(imm), .tbl_len(tbl_len), .src_a(src_a), .src_b(src_b),
    .tbl(tbl), .dst_old(dst_old), .out_valid(out_valid), .res_a(res_a),
    .res_b(res_b), .err(err));

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0: return "R3 R13";
      4'd1, 4'd2, 4'd3: return "R4 R13";
      4'd4: return "R5 R7 R13";
      4'd5: return "R6 R7 R13";
      4'd6: return "R8";
      4'd7: return "R9";
      4'd8: return "R10";
      default: return "R12";
    endcase
  endfunction

  // Reference permute built from the requirement text.
  function automatic exp_t model(input logic [3:0] o, input logic w,
      input logic [1:0] es, input logic [3:0] im, input logic [1:0] tl,
      input logic [127:0] va, input logic [127:0] vb, input logic [127:0] vo,
      input logic [255:0] vt);
    logic [7:0] A[16], B[16], RA[16], RB[16], CAT[32];
    int nb, E, C, M, cnt, idx;
    exp_t r;
    nb = w ? 16 : 8;
    E  = 1 << int'(es);
    M  = nb / E;
    r.e = 1'b0;
    for (int k = 0; k < 16; k++) begin
      A[k] = va[8*k +: 8]; B[k] = vb[8*k +: 8]; RA[k] = 8'h00; RB[k] = 8'h00;
    end
    for (int k = 0; k < 32; k++) CAT[k] = 8'h00;
    case (o)
      4'd0: begin
        if (int'(im) >= nb) r.e = 1'b1;
        else begin
          for (int k = 0; k < nb; k++) begin CAT[k] = A[k]; CAT[k+nb] = B[k]; end
          for (int i = 0; i < nb; i++) RA[i] = CAT[i + int'(im)];
        end
      end
      4'd1, 4'd2, 4'd3: begin
        C = 1 << int'(o);
        if (E >= C) r.e = 1'b1;
        else
          for (int c = 0; c < nb; c += C)
            for (int k = 0; k < C/E; k++)
              for (int x = 0; x < E; x++)
                RA[c + (C/E - 1 - k)*E + x] = A[c + k*E + x];
      end
      4'd4, 4'd5: begin
        cnt = (int'(tl) + 1) * 8;
        for (int i = 0; i < nb; i++) begin
          idx = int'(B[i]);
          if (idx < cnt) RA[i] = vt[8*idx +: 8];
          else RA[i] = (o == 4'd5) ? vo[8*i +: 8] : 8'h00;
        end
      end
      4'd6: begin
        if (es == 2'd3) r.e = 1'b1;
        else begin
          for (int j = 0; j < M; j++)
            for (int x = 0; x < E; x++) begin
              CAT[2*j*E + x]     = A[j*E + x];
              CAT[(2*j+1)*E + x] = B[j*E + x];
            end
          for (int i = 0; i < nb; i++) begin RA[i] = CAT[i]; RB[i] = CAT[nb+i]; end
        end
      end
      4'd7: begin
        if (es == 2'd3) r.e = 1'b1;
        else begin
          for (int k = 0; k < nb; k++) begin CAT[k] = A[k]; CAT[k+nb] = B[k]; end
          for (int j = 0; j < M; j++)
            for (int x = 0; x < E; x++) begin
              RA[j*E + x] = CAT[2*j*E + x];
              RB[j*E + x] = CAT[(2*j+1)*E + x];
            end
        end
      end
      4'd8: begin
        if (es == 2'd3) r.e = 1'b1;
        else
          for (int j = 0; j < M; j += 2)
            for (int x = 0; x < E; x++) begin
              RA[j*E + x]     = A[j*E + x];
              RA[(j+1)*E + x] = B[j*E + x];
              RB[j*E + x]     = A[(j+1)*E + x];
              RB[(j+1)*E + x] = B[(j+1)*E + x];
            end
      end
      default: r.e = 1'b1;
    endcase
    if (r.e) begin
      r.a = va; r.b = '0;
    end else begin
      for (int k = 0; k < 16; k++) begin r.a[8*k +: 8] = RA[k]; r.b[8*k +: 8] = RB[k]; end
    end
    return r;
  endfunction

  task automatic send(input logic [3:0] o, input logic w, input logic [1:0] es,
      input logic [3:0] im, input logic [1:0] tl, input logic [127:0] va,
      input logic [127:0] vb, input logic [127:0] vo, input string tag);
    exp_t x;
    @(negedge clk);
    op = o; wide = w; esize = es; imm = im; tbl_len = tl;
    src_a = va; src_b = vb; dst_old = vo; in_valid = 1'b1;
    x = model(o, w, es, im, tl, va, vb, vo, tbl);
    x.tag = (tag == "") ? tag_of(o) : tag;
    sb_q.push_back(x);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  // Monitor: compare each result against the scoreboard, check holds on idle cycles.
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        n_checks++;
        if (sb_q.size() == 0) begin
          n_fails++;
          $display("FAIL R1: out_valid=1 expected=0 (no request pending)");
        end else begin
          last = sb_q.pop_front();
          have_last = 1'b1;
          if (res_a !== last.a || res_b !== last.b || err !== last.e) begin
            n_fails++;
            $display("FAIL %s: actual a=%h b=%h err=%b expected a=%h b=%h err=%b",
                     last.tag, res_a, res_b, err, last.a, last.b, last.e);
          end
        end
      end else if (have_last) begin
        n_checks++;
        if (res_a !== last.a || res_b !== last.b || err !== last.e) begin
          n_fails++;
          $display("FAIL R1 hold: actual a=%h b=%h err=%b expected a=%h b=%h err=%b",
                   res_a, res_b, err, last.a, last.b, last.e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  localparam logic [127:0] PA = 128'h0f0e0d0c0b0a09080706050403020100;
  localparam logic [127:0] PB = 128'h9f9e9d9c9b9a99989796959493929190;
  localparam logic [127:0] PO = 128'heeeeeeeeeeeeeeeeeeeeeeeeeeeeeeee;

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = '0; wide = 1'b0; esize = '0; imm = '0;
    tbl_len = '0; src_a = '0; src_b = '0; dst_old = '0;
    for (int k = 0; k < 32; k++) tbl[8*k +: 8] = 8'hA0 + 8'(k);
    repeat (3) @(negedge clk);
    // R2: reset state
    n_checks++;
    if (out_valid !== 1'b0 || err !== 1'b0 || res_a !== '0 || res_b !== '0) begin
      n_fails++;
      $display("FAIL R2: actual v=%b err=%b a=%h b=%h expected all zero",
               out_valid, err, res_a, res_b);
    end
    rst_n = 1'b1;
    idle(1);

    // R3 slide
    send(4'd0, 1'b1, 2'd0, 4'd0,  2'd0, PA, PB, PO, "");
    send(4'd0, 1'b1, 2'd0, 4'd3,  2'd0, PA, PB, PO, "");
    send(4'd0, 1'b1, 2'd0, 4'd15, 2'd0, PA, PB, PO, "");
    send(4'd0, 1'b0, 2'd0, 4'd7,  2'd0, PA, PB, PO, "R3 R11");
    send(4'd0, 1'b0, 2'd0, 4'd8,  2'd0, PA, PB, PO, "R12");
    idle(2);
    // R4 reversal
    send(4'd1, 1'b1, 2'd0, 4'd0, 2'd0, PA, PB, PO, "");
    send(4'd2, 1'b1, 2'd1, 4'd0, 2'd0, PA, PB, PO, "");
    send(4'd3, 1'b1, 2'd2, 4'd0, 2'd0, PA, PB, PO, "");
    send(4'd3, 1'b0, 2'd0, 4'd0, 2'd0, PA, PB, PO, "R4 R11");
    send(4'd2, 1'b1, 2'd2, 4'd0, 2'd0, PA, PB, PO, "R12");
    send(4'd1, 1'b1, 2'd1, 4'd0, 2'd0, PA, PB, PO, "R12");
    idle(1);
    // R5 R6 R7 lookup: indices at, below and beyond table boundaries
    send(4'd4, 1'b1, 2'd0, 4'd0, 2'd0, PA,
         128'hff20_1f_10_09_08_07_00_01_02_03_04_05_06_07_08, PO, "R5 R7");
    send(4'd4, 1'b1, 2'd0, 4'd0, 2'd3, PA,
         128'hff20_1f_10_09_08_07_00_01_02_03_04_05_06_07_08, PO, "R5 R7");
    send(4'd5, 1'b1, 2'd0, 4'd0, 2'd1, PA,
         128'h00_0f_10_11_17_18_1f_20_80_ff_05_0a_14_19_1e_03, PO, "R6 R7");
    send(4'd5, 1'b0, 2'd0, 4'd0, 2'd2, PA,
         128'h00_0f_10_11_17_18_1f_20_80_ff_05_0a_14_19_1e_03, PO, "R6 R11");
    idle(2);
    // R8 R9 R10 dual results
    send(4'd6, 1'b1, 2'd0, 4'd0, 2'd0, PA, PB, PO, "");
    send(4'd6, 1'b1, 2'd2, 4'd0, 2'd0, PA, PB, PO, "");
    send(4'd7, 1'b0, 2'd1, 4'd0, 2'd0, PA, PB, PO, "R9 R11");
    send(4'd7, 1'b1, 2'd0, 4'd0, 2'd0, PA, PB, PO, "");
    send(4'd8, 1'b1, 2'd0, 4'd0, 2'd0, PA, PB, PO, "");
    send(4'd8, 1'b1, 2'd2, 4'd0, 2'd0, PA, PB, PO, "");
    send(4'd8, 1'b0, 2'd1, 4'd0, 2'd0, PA, PB, PO, "R10 R11");
    send(4'd6, 1'b1, 2'd3, 4'd0, 2'd0, PA, PB, PO, "R12");
    send(4'd12, 1'b1, 2'd0, 4'd0, 2'd0, PA, PB, PO, "R12");
    idle(2);

    // Mixed random traffic with gaps
    for (int n = 0; n < 300; n++) begin
      logic [3:0]   ro;
      logic [127:0] rb;
      ro = 4'($urandom_range(0, 9));
      rb = {$urandom, $urandom, $urandom, $urandom};
      if (ro == 4'd4 || ro == 4'd5)
        for (int k = 0; k < 16; k++) rb[8*k +: 8] = 8'($urandom_range(0, 40));
      send(ro, 1'($urandom), 2'($urandom), 4'($urandom), 2'($urandom),
           {$urandom, $urandom, $urandom, $urandom}, rb,
           {$urandom, $urandom, $urandom, $urandom}, "");
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    idle(4);
    if (sb_q.size() != 0) begin
      n_checks++;
      n_fails++;
      $display("FAIL R1: actual pending=%0d expected=0", sb_q.size());
    end
    finish_run();
  end
endmodule